// File: doc/BRIEF.md
# Multiplying Sine/Cosine Generator with Quadrant Folding

This block turns a 16-bit binary angle and a signed reference sample into two signed products: the reference times the sine of the angle and the reference times the cosine. It is the digital core of a digital-to-resolver path. The two outputs follow the reference sample by sample, so their amplitude tracks the reference level and their polarity flips when the reference goes negative, as a multiplying converter's outputs do.

The top two angle bits select one of four quadrants. The lower 14 bits drive a pipelined rotation (shift-and-add) engine that computes the first-quadrant sine and cosine magnitudes on one shared scale. A fold stage swaps the two magnitudes in odd quadrants and applies the quadrant signs. Each magnitude is then multiplied by the reference, rounded, and saturated. Angle and reference enter together on a valid/ready handshake, and every accepted beat comes out after a fixed number of cycles, in order.

Top module: `sincos_mult_gen`

## Requirements
- R1: Bits [15:14] of the angle select the quadrant. Code 0 is 0° to 90°, 1 is 90° to 180°, 2 is 180° to 270° and 3 is 270° to 360°. Bits [13:0] give the offset inside the quadrant, with one angle LSB equal to 360°/65536. At the quadrant boundaries 0x0000, 0x4000, 0x8000 and 0xC000, the outputs land on the axis values.
- R2: The sine output is within 2 LSB of ref·sin(2π·angle/65536) for every angle code.
- R3: The cosine output is within 2 LSB of ref·cos(2π·angle/65536) for every angle code.
- R4: With a positive reference, the sine output is positive in the first half turn and negative in the second. The cosine output is positive from 270° through 90° and negative between 90° and 270°. A negative reference inverts both outputs. This is checked wherever the ideal value exceeds 3 LSB in magnitude.
- R5: The outputs scale in proportion to the reference. A zero reference gives exactly zero on both outputs at every angle.
- R6: A result that would reach +2^15 saturates to +32767. Example: reference −32768 gives cosine output 32767 at angle 0x8000 and sine output 32767 at angle 0xC000. No output ever wraps.
- R7: For reference magnitudes of at least 16384, sqrt(sin²+cos²) stays within 0.1% of |ref| at every angle.
- R8: inReady equals (not outValid) or outReady. While outValid is high and outReady is low, outValid stays high and both outputs hold their values.
- R9: With outReady held high, each accepted beat produces its result STAGES+2 clock edges after the accepting edge (20 by default). Results leave in acceptance order.
- R10: During reset and at the first edge after it, outValid is low and inReady is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Angle and reference beat offered |
| inReady | output | 1 | Beat is accepted on this edge when inValid is high |
| inAngle | input | 16 | Unsigned binary angle, full turn = 65536 |
| inRef | input | 16 | Signed reference sample |
| outValid | output | 1 | Result beat present |
| outReady | input | 1 | Downstream accepts the result |
| sinOut | output | 16 | Signed reference × sine |
| cosOut | output | 16 | Signed reference × cosine |

## Verification
The bound checker watches the handshake every cycle: ready while empty, back-pressure while stalled, and outputs held during a stall. It also checks that the number of beats in flight never exceeds the pipeline depth and that the output vector never exceeds the full-scale radius. Only the bench scenarios can show the numeric results: the error against a real-valued sine/cosine model at all 65536 angles with both full-scale references, the quadrant signs, the exact saturation codes at 180° and 270°, zero output for a zero reference, and the measured latency.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

  typedef struct packed {
    logic advance;   // whole pipe moves one step
    logic capture;   // a new beat enters the fold register
  } pipeStrobes_t;

  // First-quadrant rotation gain 0.60725293500888 in Q30
  localparam longint GAIN_Q30 = 64'sd652032874;
  // 1/(2*pi) in Q32
  localparam longint INV_TURN_Q32 = 64'sd683565276;

  // atan(2^-idx) expressed in phase units where a full turn is 2^phw
  function automatic longint atanUnits(input int idx, input int phw);
    longint sumQ60;
    longint termQ60;
    longint turnsQ62;
    if (idx == 0) return longint'(1) <<< (phw - 3);
    sumQ60 = 0;
    for (int k = 1; idx * k <= 60; k += 2) begin
      termQ60 = (longint'(1) <<< (60 - idx * k)) / longint'(k);
      if (((k - 1) / 2) % 2 == 0) sumQ60 += termQ60;
      else sumQ60 -= termQ60;
    end
    turnsQ62 = (sumQ60 >>> 30) * INV_TURN_Q32;
    return (turnsQ62 + (longint'(1) <<< (61 - phw))) >>> (62 - phw);
  endfunction

endpackage

// File: rtl/sincos_ctrl.sv
module sincos_ctrl
  import sincos_pkg::*;
#(
  parameter int LAT = 20
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         outReady,
  output logic         inReady,
  output logic         outValid,
  output pipeStrobes_t strb
);

  logic [LAT-1:0] liveQ;

  assign outValid     = liveQ[LAT-1];
  assign strb.advance = !outValid || outReady;
  assign strb.capture = inValid && strb.advance;
  assign inReady      = strb.advance;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      liveQ <= '0;
    end else if (strb.advance) begin
      liveQ <= {liveQ[LAT-2:0], inValid};
    end
  end

endmodule

// File: rtl/sincos_datapath.sv
module sincos_datapath
  import sincos_pkg::*;
#(
  parameter int ANGW   = 16,
  parameter int REFW   = 16,
  parameter int MAGW   = 16,
  parameter int GUARD  = 6,
  parameter int STAGES = 18,
  parameter int PHW    = 32
) (
  input  logic                   clk,
  input  pipeStrobes_t           strb,
  input  logic [ANGW-1:0]        inAngle,
  input  logic signed [REFW-1:0] inRef,
  output logic signed [REFW-1:0] sinOut,
  output logic signed [REFW-1:0] cosOut
);

  localparam int FRAC  = MAGW + GUARD;
  localparam int DW    = FRAC + 2;
  localparam int ZW    = PHW;
  localparam int PRODW = REFW + MAGW + 2;
  localparam longint X_INIT_L = ((GAIN_Q30 <<< FRAC) + (longint'(1) <<< 29)) >>> 30;
  localparam logic signed [DW-1:0]    X_INIT = DW'(X_INIT_L);
  localparam logic signed [DW-1:0]    RND_G  = DW'(longint'(1) <<< (GUARD - 1));
  localparam logic signed [DW-1:0]    MAG_FS = DW'(longint'(1) <<< MAGW);
  localparam logic signed [PRODW-1:0] RND_M  = PRODW'(longint'(1) <<< (MAGW - 1));
  localparam logic signed [PRODW-1:0] SAT_HI = PRODW'((longint'(1) <<< (REFW - 1)) - 1);
  localparam logic signed [PRODW-1:0] SAT_LO = PRODW'(-(longint'(1) <<< (REFW - 1)));

  // fold register
  logic [1:0]             quadFold;
  logic signed [REFW-1:0] refFold;
  logic signed [ZW-1:0]   zFold;

  always_ff @(posedge clk) begin
    if (strb.capture) begin
      quadFold <= inAngle[ANGW-1:ANGW-2];
      refFold  <= inRef;
      zFold    <= ZW'(inAngle[ANGW-3:0]) <<< (PHW - ANGW);
    end
  end

  // side pipes aligned with the rotation stages
  logic [1:0]             quadPipe [1:STAGES];
  logic signed [REFW-1:0] refPipe  [1:STAGES];

  always_ff @(posedge clk) begin
    if (strb.advance) begin
      quadPipe[1] <= quadFold;
      refPipe[1]  <= refFold;
      for (int k = 2; k <= STAGES; k++) begin
        quadPipe[k] <= quadPipe[k-1];
        refPipe[k]  <= refPipe[k-1];
      end
    end
  end

  // rotation stages
  logic signed [DW-1:0] xPipe [1:STAGES];
  logic signed [DW-1:0] yPipe [1:STAGES];
  logic signed [ZW-1:0] zPipe [1:STAGES-1];

  for (genvar i = 0; i < STAGES; i++) begin : gStage
    localparam logic signed [ZW-1:0] STEP = ZW'(atanUnits(i, PHW));
    logic signed [DW-1:0] xCur, yCur;
    logic signed [ZW-1:0] zCur;
    logic                 turnUp;

    if (i == 0) begin : gFirst
      assign xCur = X_INIT;
      assign yCur = '0;
      assign zCur = zFold;
    end else begin : gRest
      assign xCur = xPipe[i];
      assign yCur = yPipe[i];
      assign zCur = zPipe[i];
    end

    assign turnUp = !zCur[ZW-1];

    always_ff @(posedge clk) begin
      if (strb.advance) begin
        if (turnUp) begin
          xPipe[i+1] <= xCur - (yCur >>> i);
          yPipe[i+1] <= yCur + (xCur >>> i);
        end else begin
          xPipe[i+1] <= xCur + (yCur >>> i);
          yPipe[i+1] <= yCur - (xCur >>> i);
        end
      end
    end

    if (i < STAGES - 1) begin : gAngle
      always_ff @(posedge clk) begin
        if (strb.advance) zPipe[i+1] <= turnUp ? zCur - STEP : zCur + STEP;
      end
    end
  end

  // magnitude extraction, clamped to [0, 1.0]
  function automatic logic [MAGW:0] toMag(input logic signed [DW-1:0] v);
    logic signed [DW-1:0] r;
    r = (v + RND_G) >>> GUARD;
    if (r < 0) return '0;
    if (r > MAG_FS) return MAG_FS[MAGW:0];
    return r[MAGW:0];
  endfunction

  // multiply by reference, round, apply sign, saturate
  function automatic logic signed [REFW-1:0] applyRef(
    input logic signed [REFW-1:0] r,
    input logic [MAGW:0]          m,
    input logic                   neg
  );
    logic signed [PRODW-1:0] p;
    p = PRODW'(r) * $signed(PRODW'(m));
    p = (p + RND_M) >>> MAGW;
    if (neg) p = -p;
    if (p > SAT_HI) p = SAT_HI;
    if (p < SAT_LO) p = SAT_LO;
    return p[REFW-1:0];
  endfunction

  logic [1:0]    quadLast;
  logic [MAGW:0] magSin, magCos, selSin, selCos;

  always_comb begin
    quadLast = quadPipe[STAGES];
    magSin   = toMag(yPipe[STAGES]);
    magCos   = toMag(xPipe[STAGES]);
    selSin   = quadLast[0] ? magCos : magSin;
    selCos   = quadLast[0] ? magSin : magCos;
  end

  always_ff @(posedge clk) begin
    if (strb.advance) begin
      sinOut <= applyRef(refPipe[STAGES], selSin, quadLast[1]);
      cosOut <= applyRef(refPipe[STAGES], selCos, quadLast[1] ^ quadLast[0]);
    end
  end

endmodule

// File: rtl/sincos_mult_gen.sv
module sincos_mult_gen
  import sincos_pkg::*;
#(
  parameter int ANGW   = 16,
  parameter int REFW   = 16,
  parameter int MAGW   = 16,
  parameter int GUARD  = 6,
  parameter int STAGES = 18,
  parameter int PHW    = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  output logic                   inReady,
  input  logic [ANGW-1:0]        inAngle,
  input  logic signed [REFW-1:0] inRef,
  output logic                   outValid,
  input  logic                   outReady,
  output logic signed [REFW-1:0] sinOut,
  output logic signed [REFW-1:0] cosOut
);

  localparam int LAT = STAGES + 2;

  pipeStrobes_t strb;

  sincos_ctrl #(.LAT(LAT)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strb     (strb)
  );

  sincos_datapath #(
    .ANGW(ANGW), .REFW(REFW), .MAGW(MAGW),
    .GUARD(GUARD), .STAGES(STAGES), .PHW(PHW)
  ) dp_i (
    .clk     (clk),
    .strb    (strb),
    .inAngle (inAngle),
    .inRef   (inRef),
    .sinOut  (sinOut),
    .cosOut  (cosOut)
  );

endmodule

// File: rtl/sincos_mult_gen_chk.sv
module sincos_mult_gen_chk #(
  parameter int REFW = 16,
  parameter int LAT  = 20
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   inValid,
  input logic                   inReady,
  input logic                   outValid,
  input logic                   outReady,
  input logic signed [REFW-1:0] sinOut,
  input logic signed [REFW-1:0] cosOut
);

  localparam longint RAD_MAX = (longint'(1) <<< (REFW - 1)) + 2;

  int     inFlight;
  longint radSq;

  always_ff @(posedge clk) begin
    if (!rstN) inFlight <= 0;
    else inFlight <= inFlight + ((inValid && inReady) ? 1 : 0)
                              - ((outValid && outReady) ? 1 : 0);
  end

  always_comb radSq = longint'(sinOut) * longint'(sinOut) + longint'(cosOut) * longint'(cosOut);

  a_r8_ready_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady);

  a_r8_backpressure: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(sinOut) && $stable(cosOut)));

  a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rstN)
    inFlight <= LAT);

  a_r9_no_phantom: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> inFlight > 0);

  a_r7_radius_bound: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> radSq <= RAD_MAX * RAD_MAX);

endmodule

bind sincos_mult_gen sincos_mult_gen_chk #(.REFW(REFW), .LAT(STAGES + 2)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .sinOut   (sinOut),
  .cosOut   (cosOut)
);

// File: tb/sincos_mult_gen_tb_top.sv
module sincos_mult_gen_tb_top;

  localparam int  STAGES = 18;
  localparam int  LAT    = STAGES + 2;
  localparam real PI     = 3.14159265358979323846;
  localparam real TOL    = 2.0;

  logic               clk = 1'b0;
  logic               rstN;
  logic               inValid;
  logic               inReady;
  logic [15:0]        inAngle;
  logic signed [15:0] inRef;
  logic               outValid;
  logic               outReady;
  logic signed [15:0] sinOut;
  logic signed [15:0] cosOut;

  always #4 clk = ~clk;

  sincos_mult_gen #(.STAGES(STAGES)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inAngle(inAngle), .inRef(inRef), .outValid(outValid),
    .outReady(outReady), .sinOut(sinOut), .cosOut(cosOut)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0]        qAng [64];
  logic signed [15:0] qRef [64];
  int                 qCyc [64];
  int  wrCnt = 0, rdCnt = 0, cyc = 0;
  bit  stallMode = 0, latArmed = 0, prevStall = 0, lastInFire = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic signed [15:0] keptSin, keptCos;

  function automatic real absr(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  task automatic tally(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic checkBeat(input logic [15:0] a, input logic signed [15:0] r,
                           input logic signed [15:0] s, input logic signed [15:0] c);
    real th, eS, eC, rad, mag;
    th  = 2.0 * PI * real'(a) / 65536.0;
    eS  = real'(r) * $sin(th);
    eC  = real'(r) * $cos(th);
    tally(absr(real'(s) - eS) <= TOL, "R2", $sformatf("sin a=%h r=%0d", a, r), s, $rtoi(eS));
    tally(absr(real'(c) - eC) <= TOL, "R3", $sformatf("cos a=%h r=%0d", a, r), c, $rtoi(eC));
    if (eS > 3.0)  tally(s > 0, "R4", $sformatf("sin sign a=%h", a), s, $rtoi(eS));
    if (eS < -3.0) tally(s < 0, "R4", $sformatf("sin sign a=%h", a), s, $rtoi(eS));
    if (eC > 3.0)  tally(c > 0, "R4", $sformatf("cos sign a=%h", a), c, $rtoi(eC));
    if (eC < -3.0) tally(c < 0, "R4", $sformatf("cos sign a=%h", a), c, $rtoi(eC));
    if (a[13:0] == 14'd0)
      tally(absr(real'(s) - eS) <= TOL && absr(real'(c) - eC) <= TOL, "R1",
            $sformatf("quadrant axis a=%h sin", a), s, $rtoi(eS));
    if (r == 16'sd0) begin
      tally(s == 0, "R5", $sformatf("zero ref sin a=%h", a), s, 0);
      tally(c == 0, "R5", $sformatf("zero ref cos a=%h", a), c, 0);
    end
    if (r == 16'sd16384)
      tally(absr(real'(s) - eS) <= TOL, "R5", $sformatf("half ref sin a=%h", a), s, $rtoi(eS));
    if (r == -16'sd32768 && a == 16'h8000) tally(c == 16'sd32767, "R6", "cos sat 180", c, 32767);
    if (r == -16'sd32768 && a == 16'hC000) tally(s == 16'sd32767, "R6", "sin sat 270", s, 32767);
    mag = absr(real'(r));
    if (mag >= 16384.0) begin
      rad = $sqrt(real'(s) * real'(s) + real'(c) * real'(c));
      tally(absr(rad - mag) <= 0.001 * mag, "R7", $sformatf("radius a=%h", a), $rtoi(rad), $rtoi(mag));
    end
  endtask

  // one clock: sample just after the negedge, then move to the next negedge
  task automatic tick();
    bit inFire, outFire;
    int ri;
    #1;
    inFire  = inValid && inReady;
    outFire = outValid && outReady;
    if (prevStall) begin
      tally(outValid == 1'b1, "R8", "valid dropped in stall", outValid, 1);
      tally(sinOut == keptSin && cosOut == keptCos, "R8", "output moved in stall", sinOut, keptSin);
    end
    if (stallMode) tally(inReady == (!outValid || outReady), "R8", "ready rule", inReady, !outValid || outReady);
    prevStall = outValid && !outReady;
    keptSin = sinOut;
    keptCos = cosOut;
    if (outFire) begin
      if (rdCnt == wrCnt) begin
        tally(1'b0, "R9", "result with nothing pending", rdCnt, wrCnt);
      end else begin
        ri = rdCnt % 64;
        if (latArmed) begin
          tally(cyc - qCyc[ri] == LAT, "R9", "latency", cyc - qCyc[ri], LAT);
          latArmed = 0;
        end
        checkBeat(qAng[ri], qRef[ri], sinOut, cosOut);
        rdCnt++;
      end
    end
    if (inFire) begin
      qAng[wrCnt % 64] = inAngle;
      qRef[wrCnt % 64] = inRef;
      qCyc[wrCnt % 64] = cyc;
      wrCnt++;
    end
    lastInFire = inFire;
    @(negedge clk);
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    outReady = stallMode ? lfsr[0] : 1'b1;
  endtask

  task automatic send(input logic [15:0] a, input logic signed [15:0] r);
    inValid = 1'b1;
    inAngle = a;
    inRef   = r;
    do tick(); while (!lastInFire);
  endtask

  task automatic drain();
    inValid = 1'b0;
    while (rdCnt != wrCnt) tick();
  endtask

  initial begin
    rstN = 1'b0; inValid = 1'b0; outReady = 1'b1; inAngle = '0; inRef = '0;
    repeat (3) @(negedge clk);
    #1;
    tally(outValid == 1'b0, "R10", "valid in reset", outValid, 0);
    tally(inReady == 1'b1, "R10", "ready in reset", inReady, 1);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    tally(outValid == 1'b0, "R10", "valid after reset", outValid, 0);
    tally(inReady == 1'b1, "R10", "ready after reset", inReady, 1);
    @(negedge clk);

    // R9 latency of a lone beat into an empty pipe
    latArmed = 1;
    send(16'h1234, 16'sd30000);
    drain();

    // R1 / R6 / R5 directed corners
    for (int q = 0; q < 4; q++) send(16'(q * 16384), 16'sd20000);
    send(16'h3FFF, 16'sd20000);
    send(16'h4001, 16'sd20000);
    send(16'h8000, -16'sd32768);
    send(16'hC000, -16'sd32768);
    for (int k = 0; k < 16; k++) send(16'(k * 4099), 16'sd0);
    drain();

    // R2 R3 R4 R7: every angle at both full-scale polarities
    for (int a = 0; a < 65536; a++) send(16'(a), 16'sd32767);
    for (int a = 0; a < 65536; a++) send(16'(a), -16'sd32768);
    drain();

    // R5 proportional scale and R8 stalls
    stallMode = 1;
    for (int a = 0; a < 65536; a += 64) send(16'(a + 5), 16'sd16384);
    drain();
    stallMode = 0;
    outReady = 1'b1;
    tick();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run incomplete actual=%0d expected=%0d", rdCnt, wrCnt);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule